// File: doc/BRIEF.md
# Three-Wire Transceiver Configuration Writer

This block programs a radio transceiver through a three-wire serial path made of a serial clock, a data line and a latch enable. A host presents a configuration word and pulses a start strobe. The block raises the latch enable and shifts the word out most significant bit first. Data changes only on falling serial-clock edges, so the transceiver samples every bit on a rising edge with a full half period of setup. After the last bit, the latch enable drops together with the final falling clock edge. The transceiver commits the shifted word on that falling edge. The two lowest bits of the word, which are the last two shifted, pick the destination register: 00 reference frequency, 01 transmit frequency, 10 receive frequency, 11 mode.

The serial clock is derived from the system clock. Each half period lasts `HALF_CYC` system cycles, and this count is chosen so the data setup before each rising edge is at least 45 ns. A data-mode input holds the latch enable high. While data mode is active, no write starts and the serial lines stay still, so no transceiver register can change. The host should change data mode only while the block is not busy.

Top module: `cfg3w_writer`

## Requirements
- R1: After reset, ser_le, ser_clk, ser_data and busy are all 0.
- R2: A start pulse seen while idle with data_mode low raises ser_le on the next cycle. ser_le then stays high for exactly WORD_W serial periods, which is 2*WORD_W*HALF_CYC system cycles.
- R3: While ser_le is high, exactly WORD_W rising serial-clock edges occur. The bits they sample form the host word, most significant bit first.
- R4: ser_data changes only on a falling serial-clock edge or when ser_le changes. It is stable for at least HALF_CYC system cycles before every rising edge and never changes while ser_clk is high.
- R5: ser_le falls in the same cycle as the last falling serial-clock edge, with no rising edge in between. The committed word goes to the register indexed by its bits [1:0] (00 reference, 01 transmit, 10 receive, 11 mode).
- R6: busy rises the cycle after an accepted start. It stays high until one full serial period (2*HALF_CYC cycles) after ser_le falls, which is 2*(WORD_W+1)*HALF_CYC cycles in total.
- R7: A start pulse that arrives while busy is ignored. The write in progress keeps its word, and no extra write follows.
- R8: While data_mode is high, ser_le is high and start is ignored. ser_clk and ser_data make no edges, so every transceiver register keeps its value, including after data_mode returns low.
- R9: Outside a write, ser_clk and ser_data stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request to write `word` |
| word | input | WORD_W | Configuration word; bits [1:0] select the register |
| data_mode | input | 1 | High holds the latch enable high and blocks writes |
| busy | output | 1 | High while a write and its trailing idle period run |
| ser_clk | output | 1 | Serial clock; the transceiver samples on its rising edge |
| ser_data | output | 1 | Serial data, MSB first |
| ser_le | output | 1 | Latch enable; its falling edge commits the word |

## Verification
The bench builds the block with WORD_W = 24 and HALF_CYC = 10. With the 5 ns system clock, each half period is 50 ns, so the 45 ns setup rule becomes a cycle count the receiver model can measure directly. A write then takes 500 cycles, which leaves room for a few dozen random and directed writes. These cover every register index, all-zero and all-one words, back-to-back starts, a start injected mid-write, and entry into and exit from data mode.

// File: rtl/cfg3w_writer.sv
`timescale 1ns/1ps
module cfg3w_writer #(
  parameter int WORD_W   = 24,
  parameter int HALF_CYC = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  input  logic              data_mode,
  output logic              busy,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              ser_le
);
  localparam int CNT_W = $clog2(2*HALF_CYC+1);
  localparam int BIT_W = $clog2(WORD_W);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  nbit;
  logic [WORD_W-1:0] sreg;
  logic              sclk, le_q;

  wire last_half = (cnt == CNT_W'(HALF_CYC-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      nbit <= '0;
      sreg <= '0;
      sclk <= 1'b0;
      le_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start && !data_mode) begin
          st   <= S_SHIFT;
          sreg <= word;
          le_q <= 1'b1;
          cnt  <= '0;
          nbit <= '0;
          sclk <= 1'b0;
        end
        S_SHIFT: if (last_half) begin
          cnt  <= '0;
          sclk <= !sclk;
          if (sclk) begin
            if (nbit == BIT_W'(WORD_W-1)) begin
              le_q <= 1'b0;
              st   <= S_GAP;
            end else begin
              nbit <= nbit + 1'b1;
              sreg <= {sreg[WORD_W-2:0], 1'b0};
            end
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_GAP: if (cnt == CNT_W'(2*HALF_CYC-1)) begin
          st  <= S_IDLE;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign ser_clk  = sclk;
  assign ser_data = (st == S_SHIFT) & sreg[WORD_W-1];
  assign ser_le   = le_q | data_mode;

  assert_start_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !data_mode) |=> (busy && ser_le && !ser_clk));

  assert_stable_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

  assert_commit_clk_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_le) |-> !ser_clk);

  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st == S_SHIFT) |=> busy);

  assert_le_forced_R8: assert property (@(posedge clk) disable iff (!rst_n)
    data_mode |-> ser_le);

  assert_mode_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_mode && !busy) |=> !busy);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_clk && !ser_data));
endmodule

// File: tb/test_cfg3w_writer.sv
`timescale 1ns/1ps
module test_cfg3w_writer;
  localparam int W = 24;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] word = '0;
  logic data_mode = 1'b0;
  logic busy, ser_clk, ser_data, ser_le;

  cfg3w_writer #(.WORD_W(W), .HALF_CYC(H)) i_cfg3w_writer (
    .clk(clk), .rst_n(rst_n), .start(start), .word(word), .data_mode(data_mode),
    .busy(busy), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int reg_index(input logic [W-1:0] w);
    return int'(w[1:0]);
  endfunction

  function automatic int busy_len();
    return 2*(W+1)*H;
  endfunction

  // receiver model: shift on rising ser_clk while ser_le is high, commit on ser_le fall
  logic [W-1:0] rx_sh = '0;
  logic [W-1:0] rx_reg [4];
  logic [W-1:0] exp_reg [4];
  int rx_rises = 0, stable = 0, le_width = 0, commits = 0;
  logic p_clk = 1'b0, p_le = 1'b0, p_data = 1'b0;
  bit mon_en = 1'b0;

  initial for (int i = 0; i < 4; i++) begin rx_reg[i] = '0; exp_reg[i] = '0; end

  always @(negedge clk) if (mon_en) begin
    if (ser_data != p_data) begin
      chk(!ser_clk && (p_clk || ser_le != p_le), "R4 data edge placement", ser_data, p_data);
      stable = 1;
    end else stable++;
    if (ser_clk && !p_clk) begin
      chk(ser_le && !data_mode, "R9/R8 clock rise outside write", ser_le, 1);
      chk(stable >= H, "R4 setup cycles", stable, H);
      rx_sh = {rx_sh[W-2:0], ser_data};
      rx_rises++;
    end
    if (ser_le && !p_le) begin rx_rises = 0; le_width = 0; end
    if (ser_le) le_width++;
    if (!ser_le && p_le) begin
      chk(!ser_clk, "R5 latch falls with clock low", ser_clk, 0);
      if (rx_rises != 0) begin
        chk(rx_rises == W, "R3 rising edges per write", rx_rises, W);
        chk(le_width == 2*W*H, "R2 latch high width", le_width, 2*W*H);
      end
      rx_reg[rx_sh[1:0]] = rx_sh;
      commits++;
    end
    p_clk = ser_clk; p_le = ser_le; p_data = ser_data;
  end

  task automatic do_write(input logic [W-1:0] w, input bit inject);
    int c0, len;
    c0 = commits;
    start = 1'b1; word = w;
    @(negedge clk);
    start = 1'b0; word = ~w;
    len = 0;
    while (busy) begin
      len++;
      if (inject && len == 100) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    exp_reg[reg_index(w)] = w;
    chk(len == busy_len(), "R6 busy length", len, busy_len());
    chk(commits - c0 == 1, inject ? "R7 single commit" : "R5 one commit", commits - c0, 1);
    chk(rx_reg[reg_index(w)] == w, inject ? "R7 word kept" : "R3/R5 committed word",
        rx_reg[reg_index(w)], w);
    for (int i = 0; i < 4; i++)
      chk(rx_reg[i] == exp_reg[i], "R5 register index", rx_reg[i], exp_reg[i]);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk({ser_le, ser_clk, ser_data, busy} == 4'b0, "R1 reset state",
        {ser_le, ser_clk, ser_data, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({ser_le, ser_clk, ser_data, busy} == 4'b0, "R1 after release",
        {ser_le, ser_clk, ser_data, busy}, 0);
    mon_en = 1'b1;
    @(negedge clk);

    do_write(24'h000000, 1'b0);
    do_write(24'hFFFFFF, 1'b0);
    do_write(24'hAAAAA9, 1'b0);
    do_write(24'h555556, 1'b0);
    do_write(24'h800001, 1'b0);
    do_write(24'h3C5A62, 1'b1);

    repeat (20) do_write(W'($urandom), 1'b0);
    repeat (3) do_write(W'($urandom), 1'b1);

    // data mode: latch held high, starts ignored, no edges
    data_mode = 1'b1;
    #1;
    chk(ser_le == 1'b1, "R8 latch forced high", ser_le, 1);
    @(negedge clk);
    start = 1'b1; word = 24'h123457;
    @(negedge clk);
    start = 1'b0;
    begin
      int seen = 0;
      for (int k = 0; k < 200; k++) begin
        if (busy || ser_clk || ser_data || !ser_le) seen++;
        @(negedge clk);
      end
      chk(seen == 0, "R8 no activity in data mode", seen, 0);
    end
    data_mode = 1'b0;
    repeat (5) @(negedge clk);
    chk(ser_le == 1'b0 && !busy, "R8 idle after leaving data mode", ser_le, 0);
    for (int i = 0; i < 4; i++)
      chk(rx_reg[i] == exp_reg[i], "R8 registers unchanged", rx_reg[i], exp_reg[i]);

    do_write(24'h0F0F02, 1'b0);
    repeat (10) @(negedge clk);
    chk(!ser_clk && !ser_data, "R9 idle lines low", {ser_clk, ser_data}, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule